// File: doc/BRIEF.md
# Full-Speed USB Line Receiver

This block turns the two raw data pads of a full-speed USB link into a byte stream on a UTMI-style receive interface. Both pads are brought into a fast sampling domain that runs at four times the bit rate and is phase-locked to the byte-side clock. Every change of line level re-centres a small phase counter, so each bit is read in the middle of its cell even when the far end's clock drifts. The same domain classifies each sample as J, K, SE0 or SE1 and presents that class as the 2-bit line state.

Once the synchronisation pattern has been seen, the receiver decodes NRZI, drops the bit stuffed after a run of six ones, and packs the bits LSB first into bytes. It raises the active flag for the length of the packet. Each finished byte is handed to the slow domain with a one-cycle valid pulse, and the end of packet gives a one-cycle completion pulse. Stuffing violations, a truncated final byte and a malformed end-of-packet raise the error flag. The flag stays set until the next packet starts.

Top module: `usbrx_fs_rx`

## Requirements
- R1: `lineState` reports the synchronised pads as {D+, D-}: 0 for SE0, 1 for K (D+ low, D- high), 2 for J (D+ high, D- low) and 3 for SE1.
- R2: `rxActive` is low while idle and rises only after the eight-symbol pattern K J K J K J K K has been sampled. Any other pattern, such as K J K J K J K J, leaves it low and produces no bytes.
- R3: After the pattern, a sampled symbol equal to the previous one is a 1 bit and a change of symbol is a 0 bit. Bits are packed LSB first, and each complete byte appears on `rxData` with `rxValid` high for exactly one `clkUsb` cycle.
- R4: The bit that follows six consecutive 1 bits is dropped, so the bytes come out unchanged when the sender stuffs a 0 there.
- R5: If the bit after six consecutive 1 bits is itself a 1, `rxError` rises and no further `rxValid` pulse is given in that packet.
- R6: SE0 followed by J ends the packet. `rxActive` falls and `rxComplete` is high for exactly one `clkUsb` cycle.
- R7: If the packet ends while the bit count is not a multiple of eight, `rxError` is raised. The bytes completed before that point are still delivered.
- R8: `rxError` stays high after the packet ends and clears only when the next synchronisation pattern is detected.
- R9: The sample point re-centres on every line transition, two fast cycles after the edge. Symbol cells of 3, 4 or 5 fast cycles therefore decode correctly.
- R10: While reset is held and just after it, `rxActive`, `rxValid`, `rxComplete` and `rxError` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIo | input | 1 | Sampling clock, four times the bit rate |
| clkUsb | input | 1 | Byte-side clock, phase-related to `clkIo`, one cycle per bit time |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| dpIn | input | 1 | Raw D+ pad level |
| dmIn | input | 1 | Raw D- pad level |
| rxData | output | 8 | Received byte, meaningful while `rxValid` is high |
| rxValid | output | 1 | One-cycle strobe for each new byte |
| rxActive | output | 1 | High from synchronisation until end of packet |
| rxError | output | 1 | Error seen in the current or last packet |
| rxComplete | output | 1 | One-cycle strobe at end of packet |
| lineState | output | 2 | Current line class (SE0/K/J/SE1) |

## Verification
A pad change reaches the sampler through two synchroniser flops. It is read two fast cycles after the edge, registered by the control state, and then crosses into the byte domain through one more flop. Byte, completion and activity results therefore land within about three `clkUsb` cycles of the symbol that causes them, and the line state lands within about two. The bench drives the pads on falling `clkIo` edges and records the outputs on falling `clkUsb` edges with a monitor that counts every valid and completion cycle. Its final checks are made only after ten idle J symbols, so every due result has already arrived and any duplicated strobe shows up as an extra count.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  // Line classes; the encoding equals {D+, D-}.
  typedef enum logic [1:0] {
    LS_SE0 = 2'd0,
    LS_K   = 2'd1,
    LS_J   = 2'd2,
    LS_SE1 = 2'd3
  } lineSym_e;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_EOP  = 2'd2
  } rxState_e;

  // Strobes from control to datapath, valid in the sample cycle.
  typedef struct packed {
    logic shiftEn;
    logic clearCount;
  } dpCtrl_t;

endpackage

// File: rtl/usbrx_datapath.sv
module usbrx_datapath
  import usbrx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int OVERSAMPLE   = 4,
  parameter int SAMPLE_DELAY = 2
) (
  input  logic              clkIo,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  input  dpCtrl_t           ctrl,
  output lineSym_e          lineNow,
  output logic              sampleStb,
  output logic              rxBit,
  output logic              partial,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteTgl
);

  localparam int PH_W = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(OVERSAMPLE - 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_DELAY);
  localparam logic [BC_W-1:0] BC_LAST   = BC_W'(BYTE_W - 1);

  // Two-flop synchronisers, one per pad.
  logic [1:0] dpSync, dmSync;
  always_ff @(posedge clkIo or negedge rstN) begin
    if (!rstN) begin
      dpSync <= 2'b00;
      dmSync <= 2'b00;
    end else begin
      dpSync <= {dpSync[0], dpIn};
      dmSync <= {dmSync[0], dmIn};
    end
  end

  assign lineNow = lineSym_e'({dpSync[1], dmSync[1]});

  // Phase recovery: restart the counter on every transition.
  lineSym_e        linePrev;
  logic [PH_W-1:0] phaseCnt;
  logic            edgeSeen;

  assign edgeSeen  = (lineNow != linePrev);
  assign sampleStb = (phaseCnt == PH_SAMPLE) && !edgeSeen;

  always_ff @(posedge clkIo or negedge rstN) begin
    if (!rstN) begin
      linePrev <= LS_SE0;
      phaseCnt <= '0;
    end else begin
      linePrev <= lineNow;
      if (edgeSeen)              phaseCnt <= PH_W'(1);
      else if (phaseCnt == PH_LAST) phaseCnt <= '0;
      else                       phaseCnt <= phaseCnt + PH_W'(1);
    end
  end

  // NRZI: same symbol as the last sample is a one.
  logic prevK;
  assign rxBit = ((lineNow == LS_K) == prevK);

  always_ff @(posedge clkIo or negedge rstN) begin
    if (!rstN)          prevK <= 1'b0;
    else if (sampleStb) prevK <= (lineNow == LS_K);
  end

  // Byte assembly, LSB first.
  logic [BYTE_W-1:0] shReg;
  logic [BC_W-1:0]   bitCnt;
  logic [BYTE_W-1:0] shNext;

  assign shNext  = {rxBit, shReg[BYTE_W-1:1]};
  assign partial = (bitCnt != '0);

  always_ff @(posedge clkIo or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      byteData <= '0;
      byteTgl  <= 1'b0;
    end else if (ctrl.clearCount) begin
      bitCnt <= '0;
    end else if (ctrl.shiftEn) begin
      shReg <= shNext;
      if (bitCnt == BC_LAST) begin
        byteData <= shNext;
        byteTgl  <= ~byteTgl;
        bitCnt   <= '0;
      end else begin
        bitCnt <= bitCnt + BC_W'(1);
      end
    end
  end

  // Samples are never back to back.
  assert_sample_gap_R9: assert property (@(posedge clkIo) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  // A packet start leaves no partial byte behind.
  assert_count_cleared_R7: assert property (@(posedge clkIo) disable iff (!rstN)
    ctrl.clearCount |=> !partial);

endmodule

// File: rtl/usbrx_control.sv
module usbrx_control
  import usbrx_pkg::*;
#(
  parameter int                  STUFF_LIMIT  = 6,
  parameter int                  SYNC_LEN     = 8,
  parameter logic [SYNC_LEN-1:0] SYNC_PATTERN = 8'hAB
) (
  input  logic     clkIo,
  input  logic     rstN,
  input  logic     sampleStb,
  input  lineSym_e lineNow,
  input  logic     rxBit,
  input  logic     partial,
  output dpCtrl_t  ctrl,
  output logic     activeLvl,
  output logic     errLvl,
  output logic     cmplTgl
);

  localparam int OC_W = $clog2(STUFF_LIMIT + 1);
  localparam logic [OC_W-1:0] OC_LIMIT = OC_W'(STUFF_LIMIT);

  rxState_e            state;
  logic [SYNC_LEN-1:0] hist;
  logic [SYNC_LEN-1:0] histNext;
  logic [OC_W-1:0]     onesCnt;
  logic                isData;
  logic                isStuff;
  logic                syncHit;

  assign isData   = (lineNow == LS_K) || (lineNow == LS_J);
  assign isStuff  = (onesCnt == OC_LIMIT);
  assign histNext = {hist[SYNC_LEN-2:0], (lineNow == LS_K)};
  assign syncHit  = sampleStb && (state == ST_HUNT) && isData &&
                    (histNext == SYNC_PATTERN);
  assign activeLvl = (state != ST_HUNT);

  always_comb begin
    ctrl = '0;
    ctrl.clearCount = syncHit;
    if (sampleStb && (state == ST_DATA) && isData && !isStuff && !errLvl)
      ctrl.shiftEn = 1'b1;
  end

  always_ff @(posedge clkIo or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      hist    <= '0;
      onesCnt <= '0;
      errLvl  <= 1'b0;
      cmplTgl <= 1'b0;
    end else if (sampleStb) begin
      case (state)
        ST_HUNT: begin
          if (syncHit) begin
            state   <= ST_DATA;
            hist    <= '0;
            onesCnt <= '0;
            errLvl  <= 1'b0;
          end else if (isData) begin
            hist <= histNext;
          end else begin
            hist <= '0;
          end
        end
        ST_DATA: begin
          case (lineNow)
            LS_SE0: state <= ST_EOP;
            LS_SE1: errLvl <= 1'b1;
            default: begin
              if (isStuff) begin
                onesCnt <= '0;
                if (rxBit) errLvl <= 1'b1;
              end else if (rxBit) begin
                onesCnt <= onesCnt + OC_W'(1);
              end else begin
                onesCnt <= '0;
              end
            end
          endcase
        end
        ST_EOP: begin
          if (lineNow != LS_SE0) begin
            state   <= ST_HUNT;
            cmplTgl <= ~cmplTgl;
            if ((lineNow != LS_J) || partial) errLvl <= 1'b1;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assert_ones_bound_R4: assert property (@(posedge clkIo) disable iff (!rstN)
    onesCnt <= OC_LIMIT);

  assert_err_sticky_R8: assert property (@(posedge clkIo) disable iff (!rstN)
    (errLvl && (state != ST_HUNT)) |=> errLvl);

  assert_eop_ends_R6: assert property (@(posedge clkIo) disable iff (!rstN)
    (state == ST_EOP && sampleStb && lineNow == LS_J) |=> (state == ST_HUNT));

  assert_no_shift_after_err_R5: assert property (@(posedge clkIo) disable iff (!rstN)
    errLvl |-> !ctrl.shiftEn);

endmodule

// File: rtl/usbrx_cdc.sv
module usbrx_cdc
  import usbrx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clkUsb,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              byteTgl,
  input  logic              cmplTgl,
  input  logic              activeLvl,
  input  logic              errLvl,
  input  lineSym_e          lineNow,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxActive,
  output logic              rxError,
  output logic              rxComplete,
  output logic [1:0]        lineState
);

  // The domains are phase-locked, so one flop per signal suffices.
  // Byte data is held for many fast cycles after its toggle.
  logic byteQ, byteSeen, cmplQ, cmplSeen;

  always_ff @(posedge clkUsb or negedge rstN) begin
    if (!rstN) begin
      byteQ     <= 1'b0;
      byteSeen  <= 1'b0;
      cmplQ     <= 1'b0;
      cmplSeen  <= 1'b0;
      rxData    <= '0;
      rxActive  <= 1'b0;
      rxError   <= 1'b0;
      lineState <= 2'd0;
    end else begin
      byteQ     <= byteTgl;
      byteSeen  <= byteQ;
      cmplQ     <= cmplTgl;
      cmplSeen  <= cmplQ;
      rxData    <= byteData;
      rxActive  <= activeLvl;
      rxError   <= errLvl;
      lineState <= lineNow;
    end
  end

  assign rxValid    = byteQ ^ byteSeen;
  assign rxComplete = cmplQ ^ cmplSeen;

  assert_valid_pulse_R3: assert property (@(posedge clkUsb) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_complete_pulse_R6: assert property (@(posedge clkUsb) disable iff (!rstN)
    rxComplete |=> !rxComplete);

  assert_valid_in_packet_R2: assert property (@(posedge clkUsb) disable iff (!rstN)
    rxValid |-> rxActive);

endmodule

// File: rtl/usbrx_fs_rx.sv
module usbrx_fs_rx
  import usbrx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int OVERSAMPLE   = 4,
  parameter int SAMPLE_DELAY = 2,
  parameter int STUFF_LIMIT  = 6
) (
  input  logic              clkIo,
  input  logic              clkUsb,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxActive,
  output logic              rxError,
  output logic              rxComplete,
  output logic [1:0]        lineState
);

  dpCtrl_t           ctrl;
  lineSym_e          lineNow;
  logic              sampleStb, rxBit, partial, byteTgl;
  logic [BYTE_W-1:0] byteData;
  logic              activeLvl, errLvl, cmplTgl;

  usbrx_datapath #(
    .BYTE_W(BYTE_W), .OVERSAMPLE(OVERSAMPLE), .SAMPLE_DELAY(SAMPLE_DELAY)
  ) u_datapath (
    .clkIo(clkIo), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .ctrl(ctrl),
    .lineNow(lineNow), .sampleStb(sampleStb), .rxBit(rxBit),
    .partial(partial), .byteData(byteData), .byteTgl(byteTgl)
  );

  usbrx_control #(
    .STUFF_LIMIT(STUFF_LIMIT)
  ) u_control (
    .clkIo(clkIo), .rstN(rstN), .sampleStb(sampleStb), .lineNow(lineNow),
    .rxBit(rxBit), .partial(partial), .ctrl(ctrl), .activeLvl(activeLvl),
    .errLvl(errLvl), .cmplTgl(cmplTgl)
  );

  usbrx_cdc #(
    .BYTE_W(BYTE_W)
  ) u_cdc (
    .clkUsb(clkUsb), .rstN(rstN), .byteData(byteData), .byteTgl(byteTgl),
    .cmplTgl(cmplTgl), .activeLvl(activeLvl), .errLvl(errLvl),
    .lineNow(lineNow), .rxData(rxData), .rxValid(rxValid),
    .rxActive(rxActive), .rxError(rxError), .rxComplete(rxComplete),
    .lineState(lineState)
  );

endmodule

// File: tb/usbrx_fs_rx_tb.sv
module usbrx_fs_rx_tb;

  localparam logic [1:0] SYM_SE0 = 2'd0;
  localparam logic [1:0] SYM_K   = 2'd1;
  localparam logic [1:0] SYM_J   = 2'd2;
  localparam logic [1:0] SYM_SE1 = 2'd3;

  logic clkIo = 1'b0;
  logic [1:0] divCnt = 2'd0;
  logic clkUsb;
  logic rstN = 1'b0;
  logic dpIn = 1'b1;
  logic dmIn = 1'b0;
  logic [7:0] rxData;
  logic rxValid, rxActive, rxError, rxComplete;
  logic [1:0] lineState;

  always #2.5 clkIo = ~clkIo;
  always @(negedge clkIo) divCnt <= divCnt + 2'd1;
  assign clkUsb = divCnt[1];

  usbrx_fs_rx u_dut (
    .clkIo(clkIo), .clkUsb(clkUsb), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn),
    .rxData(rxData), .rxValid(rxValid), .rxActive(rxActive),
    .rxError(rxError), .rxComplete(rxComplete), .lineState(lineState)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // Monitor
  logic [7:0] gotB [0:31];
  int gotN = 0;
  int cmplN = 0;
  bit sawActive = 0;

  always @(negedge clkUsb) begin
    if (rstN) begin
      if (rxValid && gotN < 32) begin
        gotB[gotN] = rxData;
        gotN = gotN + 1;
      end
      if (rxComplete) cmplN = cmplN + 1;
      if (rxActive) sawActive = 1;
    end
  end

  // Transmit model
  logic txBits [0:511];
  int txN = 0;
  int onesRun = 0;
  bit stuffOn = 1;
  bit jitterOn = 0;
  int symIdx = 0;

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendSym(input logic [1:0] s);
    int w;
    w = 4;
    if (jitterOn) begin
      case (symIdx % 3)
        0: w = 5;
        1: w = 4;
        default: w = 3;
      endcase
    end
    symIdx++;
    dpIn = s[1];
    dmIn = s[0];
    repeat (w) @(negedge clkIo);
  endtask

  task automatic startPkt();
    txN = 0;
    onesRun = 0;
    gotN = 0;
    cmplN = 0;
    sawActive = 0;
  endtask

  task automatic pushBit(input logic b);
    txBits[txN] = b;
    txN++;
    if (stuffOn) begin
      if (b) onesRun++;
      else onesRun = 0;
      if (onesRun == 6) begin
        txBits[txN] = 1'b0;
        txN++;
        onesRun = 0;
      end
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) pushBit(b[i]);
  endtask

  task automatic sendSync();
    for (int i = 0; i < 3; i++) begin
      sendSym(SYM_K);
      sendSym(SYM_J);
    end
    sendSym(SYM_K);
    sendSym(SYM_K);
  endtask

  task automatic transmit();
    logic lvlK;
    sendSync();
    lvlK = 1'b1;
    for (int i = 0; i < txN; i++) begin
      if (!txBits[i]) lvlK = ~lvlK;
      sendSym(lvlK ? SYM_K : SYM_J);
    end
    sendSym(SYM_SE0);
    sendSym(SYM_SE0);
    for (int i = 0; i < 10; i++) sendSym(SYM_J);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendSym(SYM_J);
  endtask

  // Scenarios
  task automatic t_reset();
    chk("R10 active after reset", int'(rxActive), 0);
    chk("R10 valid after reset", int'(rxValid), 0);
    chk("R10 complete after reset", int'(rxComplete), 0);
    chk("R10 error after reset", int'(rxError), 0);
    chk("R1 idle J", int'(lineState), 2);
  endtask

  task automatic t_lineState();
    sendSym(SYM_K); sendSym(SYM_K);
    chk("R1 K", int'(lineState), 1);
    sendSym(SYM_SE0); sendSym(SYM_SE0);
    chk("R1 SE0", int'(lineState), 0);
    sendSym(SYM_SE1); sendSym(SYM_SE1);
    chk("R1 SE1", int'(lineState), 3);
    idle(4);
    chk("R1 J", int'(lineState), 2);
    chk("R2 no activity from line noise", int'(sawActive), 0);
  endtask

  task automatic t_basic();
    startPkt();
    pushByte(8'hA5);
    pushByte(8'h3C);
    transmit();
    chk("R2 active seen", int'(sawActive), 1);
    chk("R3 byte count", gotN, 2);
    chk("R3 byte0", int'(gotB[0]), 'hA5);
    chk("R3 byte1", int'(gotB[1]), 'h3C);
    chk("R6 one complete cycle", cmplN, 1);
    chk("R6 active low after EOP", int'(rxActive), 0);
    chk("R3 no error", int'(rxError), 0);
  endtask

  task automatic t_stuff();
    startPkt();
    pushByte(8'hFF);
    pushByte(8'hFF);
    pushByte(8'h7E);
    pushByte(8'hFC);
    transmit();
    chk("R4 byte count", gotN, 4);
    chk("R4 byte0", int'(gotB[0]), 'hFF);
    chk("R4 byte1", int'(gotB[1]), 'hFF);
    chk("R4 byte2", int'(gotB[2]), 'h7E);
    chk("R4 byte3", int'(gotB[3]), 'hFC);
    chk("R4 no error", int'(rxError), 0);
  endtask

  task automatic t_jitter();
    jitterOn = 1;
    startPkt();
    pushByte(8'h96);
    pushByte(8'h00);
    pushByte(8'hFF);
    pushByte(8'h5B);
    transmit();
    jitterOn = 0;
    chk("R9 byte count", gotN, 4);
    chk("R9 byte0", int'(gotB[0]), 'h96);
    chk("R9 byte1", int'(gotB[1]), 'h00);
    chk("R9 byte2", int'(gotB[2]), 'hFF);
    chk("R9 byte3", int'(gotB[3]), 'h5B);
    chk("R9 no error", int'(rxError), 0);
  endtask

  task automatic t_stuffErr();
    stuffOn = 0;
    startPkt();
    pushByte(8'hFF);
    pushByte(8'h55);
    transmit();
    stuffOn = 1;
    chk("R5 error raised", int'(rxError), 1);
    chk("R5 no bytes after violation", gotN, 0);
    chk("R6 complete after bad packet", cmplN, 1);
  endtask

  task automatic t_sticky();
    idle(8);
    chk("R8 error held while idle", int'(rxError), 1);
    startPkt();
    pushByte(8'h12);
    transmit();
    chk("R8 error cleared by new packet", int'(rxError), 0);
    chk("R8 next packet byte", int'(gotB[0]), 'h12);
  endtask

  task automatic t_partial();
    startPkt();
    pushByte(8'h5A);
    pushBit(1'b1); pushBit(1'b0); pushBit(1'b1); pushBit(1'b0);
    transmit();
    chk("R7 complete byte kept", gotN, 1);
    chk("R7 byte value", int'(gotB[0]), 'h5A);
    chk("R7 error on short byte", int'(rxError), 1);
    chk("R7 complete pulse", cmplN, 1);
  endtask

  task automatic t_falseSync();
    startPkt();
    for (int i = 0; i < 4; i++) begin
      sendSym(SYM_K);
      sendSym(SYM_J);
    end
    idle(10);
    chk("R2 wrong pattern stays idle", int'(sawActive), 0);
    chk("R2 wrong pattern no bytes", gotN, 0);
    chk("R2 wrong pattern no complete", cmplN, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (12) @(negedge clkIo);
    rstN = 1'b1;
    repeat (16) @(negedge clkIo);
    t_reset();
    t_lineState();
    t_basic();
    t_stuff();
    t_jitter();
    t_stuffErr();
    t_sticky();
    t_partial();
    t_falseSync();
    finish();
  end

  initial begin
    repeat (150000) @(posedge clkIo);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

endmodule